// File: doc/BRIEF.md
# Memory-Mapped I/O Address Decoder

This block sits between an 8-bit processor bus and two targets: a byte-wide RAM whose reads and writes are both clocked, and a small I/O port made of switch inputs and an LED output register. It looks at the two most significant address bits. Addresses with both bits set (0xC0 to 0xFF) belong to the I/O port. All other addresses (0x00 to 0xBF) belong to the RAM.

A write goes only to the target that owns the address. The RAM write enable is masked for I/O addresses, and the LED register loads only on I/O writes. Read data comes back one cycle after the read strobe in both regions. The RAM output arrives with that latency by its nature. On the I/O side, the region select and the synchronized switch value are captured on the same edge, so both sources line up. The switch inputs pass through a two-flop synchronizer before any read can return them.

Top module: `mmio_decode`

## Requirements
- R1: An address whose bits [7:6] equal 2'b11 (0xC0 to 0xFF) selects the I/O port. Any other address selects the RAM.
- R2: `ram_we` is high only while `cpu_we` is high with a RAM-region address. `ram_en` is high only while `cpu_we` or `cpu_re` is high with a RAM-region address. Both are low when the bus is idle or an I/O address is presented.
- R3: `ram_addr` always equals `cpu_addr`, and `ram_wdata` always equals `cpu_wdata`.
- R4: A write to any I/O address, 0xFF included, loads `cpu_wdata` into `led_out` on that clock edge.
- R5: `led_out` does not change on RAM-region writes, on reads, or on idle cycles. An I/O write never changes a RAM location.
- R6: `led_out` is 0 while `rst_n` is low and just after reset is released, including a reset applied in the middle of operation.
- R7: A read of an I/O address returns, after the read edge, the switch value that the two-flop synchronizer held at that edge. A switch change is therefore first seen by a read issued on the third rising edge after the change.
- R8: A read of a RAM-region address makes `cpu_rdata` equal the RAM's registered output in the cycle after the read edge.
- R9: The read-return select and the captured I/O byte change only on read edges. Between reads, `cpu_rdata` keeps showing the last I/O byte, even if the switches change.
- R10: After reset, the read-return select points at the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 8 | Processor byte address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Processor write strobe |
| cpu_re | input | 1 | Processor read strobe |
| cpu_rdata | output | 8 | Read data returned to the processor |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | Registered RAM read data |
| sw_in | input | 8 | Asynchronous switch inputs |
| led_out | output | 8 | LED output register |

## Verification
Two actions can fall on the same clock edge: a switch change travelling through the synchronizer, and an I/O read that captures the synchronizer's output. The bench changes the switches and then issues I/O reads on the next three edges. The first two reads must return the old value and the third the new one. A related overlap also gets a test. After an I/O read, the bench changes the switches while the bus is idle, and `cpu_rdata` must not move.

// File: rtl/mmio_decode.sv
module mmio_decode #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_we,
  input  logic          cpu_re,
  output logic [DW-1:0] cpu_rdata,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  input  logic [DW-1:0] sw_in,
  output logic [DW-1:0] led_out
);
  localparam logic [1:0] IO_REGION = 2'b11;

  logic          hit_io;
  logic [DW-1:0] sw_sync [SYNC_STAGES];
  logic          sel_io_q;
  logic [DW-1:0] io_q;

  assign hit_io    = (cpu_addr[AW-1:AW-2] == IO_REGION);
  assign ram_en    = (cpu_we | cpu_re) & ~hit_io;
  assign ram_we    = cpu_we & ~hit_io;
  assign ram_addr  = cpu_addr;
  assign ram_wdata = cpu_wdata;
  assign cpu_rdata = sel_io_q ? io_q : ram_rdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 led_out <= '0;
    else if (cpu_we && hit_io)  led_out <= cpu_wdata;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sw_sync[g] <= '0;
        else        sw_sync[g] <= (g == 0) ? sw_in : sw_sync[(g == 0) ? 0 : g-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_io_q <= 1'b0;
      io_q     <= '0;
    end else if (cpu_re) begin
      sel_io_q <= hit_io;
      if (hit_io) io_q <= sw_sync[SYNC_STAGES-1];
    end
endmodule

// File: rtl/mmio_decode_chk.sv
module mmio_decode_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cpu_addr,
  input logic [DW-1:0] cpu_wdata,
  input logic          cpu_we,
  input logic          cpu_re,
  input logic [DW-1:0] cpu_rdata,
  input logic          ram_en,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic [DW-1:0] ram_wdata,
  input logic [DW-1:0] ram_rdata,
  input logic [DW-1:0] led_out
);
  logic io_a;
  assign io_a = &cpu_addr[AW-1:AW-2];

  // R2
  ram_we_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_a |-> !ram_we && !ram_en);

  // R2
  ram_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_we && !cpu_re) |-> !ram_en && !ram_we);

  // R3
  ram_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_addr == cpu_addr && ram_wdata == cpu_wdata);

  // R4
  led_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && io_a) |=> led_out == $past(cpu_wdata));

  // R5
  led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && io_a) |=> $stable(led_out));

  // R8
  mem_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_re && !io_a) |=> cpu_rdata == ram_rdata);
endmodule

bind mmio_decode mmio_decode_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata), .ram_en(ram_en),
  .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
  .ram_rdata(ram_rdata), .led_out(led_out)
);

// File: tb/mmio_decode_tb.sv
module mmio_decode_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 12;
  // {is_read, addr, data, expected}: writes expect led_out, reads expect cpu_rdata
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h10, 8'hAA, 8'h00},
    {1'b0, 8'h80, 8'hBB, 8'h00},
    {1'b0, 8'h40, 8'hCC, 8'h00},
    {1'b0, 8'hC0, 8'h11, 8'h11},
    {1'b1, 8'h10, 8'h00, 8'hAA},
    {1'b1, 8'hC3, 8'h00, 8'h5A},
    {1'b1, 8'h80, 8'h00, 8'hBB},
    {1'b0, 8'hBF, 8'h77, 8'h11},
    {1'b0, 8'hFF, 8'h0D, 8'h0D},
    {1'b1, 8'hBF, 8'h00, 8'h77},
    {1'b1, 8'hFF, 8'h00, 8'h5A},
    {1'b1, 8'h40, 8'h00, 8'hCC}
  };

  logic clk = 0, rst_n = 0;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0, sw_in = 0;
  logic cpu_we = 0, cpu_re = 0;
  logic [7:0] cpu_rdata, ram_addr, ram_wdata, led_out;
  logic ram_en, ram_we;
  logic [7:0] mem [256];
  logic [7:0] ram_q = 0;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  always_ff @(posedge clk)
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_q <= mem[ram_addr];
    end

  mmio_decode dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata), .ram_en(ram_en),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_q), .sw_in(sw_in), .led_out(led_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic re, input logic [7:0] a, input logic [7:0] d);
    cpu_we = we; cpu_re = re; cpu_addr = a; cpu_wdata = d;
    #1;
    chk("R2 ram_we", {7'b0, ram_we}, {7'b0, we && a[7:6] != 2'b11});
    chk("R2 ram_en", {7'b0, ram_en}, {7'b0, (we || re) && a[7:6] != 2'b11});
    chk("R3 ram_addr", ram_addr, a);
    chk("R3 ram_wdata", ram_wdata, d);
    @(posedge clk); @(negedge clk);
    cpu_we = 0; cpu_re = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 5000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    sw_in = 8'h5A;
    idle(3);
    chk("R6 led in reset", led_out, 8'h00);
    rst_n = 1;
    idle(4);
    chk("R6 led after reset", led_out, 8'h00);
    chk("R10 select on RAM after reset", cpu_rdata, ram_q);
    chk("R2 idle ram_en", {7'b0, ram_en}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      step(!VEC[v][24], VEC[v][24], VEC[v][23:16], VEC[v][15:8]);
      if (VEC[v][24]) chk($sformatf("R1 R7 R8 read %h", VEC[v][23:16]), cpu_rdata, VEC[v][7:0]);
      else            chk($sformatf("R1 R4 R5 led after write %h", VEC[v][23:16]), led_out, VEC[v][7:0]);
    end

    // R5: I/O writes leave RAM locations untouched
    chk("R5 ram at C0", mem[8'hC0], 8'h00);
    chk("R5 ram at FF", mem[8'hFF], 8'h00);
    // R5: reads do not move LEDs
    chk("R5 led after reads", led_out, 8'h0D);

    // R9: hold of I/O byte between reads
    step(1'b0, 1'b1, 8'hE0, 8'h00);
    chk("R7 io read", cpu_rdata, 8'h5A);
    sw_in = 8'hA5;
    idle(5);
    chk("R9 hold while idle", cpu_rdata, 8'h5A);

    // R7: synchronizer latency against back-to-back reads
    sw_in = 8'h3C;
    step(1'b0, 1'b1, 8'hC1, 8'h00);
    chk("R7 first edge old value", cpu_rdata, 8'hA5);
    step(1'b0, 1'b1, 8'hC1, 8'h00);
    chk("R7 second edge old value", cpu_rdata, 8'hA5);
    step(1'b0, 1'b1, 8'hC1, 8'h00);
    chk("R7 third edge new value", cpu_rdata, 8'h3C);

    // R4: a write to 0xFF reaches the LEDs
    step(1'b1, 1'b0, 8'hFF, 8'h0E);
    chk("R4 led from FF", led_out, 8'h0E);
    // R5: RAM write right after does not touch LEDs
    step(1'b1, 1'b0, 8'h3F, 8'h99);
    chk("R5 led after RAM write", led_out, 8'h0E);
    step(1'b0, 1'b1, 8'h3F, 8'h00);
    chk("R8 RAM readback 3F", cpu_rdata, 8'h99);

    // R6 R10: reset mid-run
    step(1'b0, 1'b1, 8'hC2, 8'h00);
    rst_n = 0;
    #1;
    chk("R6 led during mid reset", led_out, 8'h00);
    idle(2);
    rst_n = 1;
    idle(1);
    chk("R6 led after mid reset", led_out, 8'h00);
    chk("R10 select back on RAM", cpu_rdata, ram_q);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule